// File: doc/BRIEF.md
# Streaming Data Segmenter

This block splits one outgoing streaming-transport PDU into packet segments. A command carries the PDU length in bytes and a 16-bit stream identifier. The block then emits, for each segment, a header descriptor followed by that segment's payload bytes. The payload bytes come from a byte stream on the input side. Each header carries the streaming format type, a segment kind, the stream identifier and the segment's byte count.

The segment kind depends on the PDU length and the `MAX_SEG` parameter. A PDU that fits in one segment gets the single kind. A longer PDU is sent as one start segment, then zero or more continuation segments, then one end segment. Every segment except the last is exactly `MAX_SEG` bytes long, and the last one carries the remainder.

All three streams (command, header and payload) use valid/ready handshakes:
- A transfer happens on a rising clock edge where valid and ready are both high.
- A source holds valid and its data stable until the transfer.
- The payload path is a combinational pass-through during a segment's payload phase. Back-pressure on the output reaches the input in the same cycle, so `in_ready` follows `out_ready` and `out_valid` follows `in_valid`.
- A new command is not taken while a PDU is in progress.

Top module: `ds_segmenter`

## Requirements
- R1: After reset `cmd_ready` is 1, while `hdr_valid`, `out_valid`, `in_ready` and `cmd_err` are 0.
- R2: A command whose length is 0 or greater than `MAX_PDU` (65536) is consumed without producing any header. `cmd_err` is 1 for exactly the one cycle after its handshake, and `cmd_ready` stays 1.
- R3: A PDU of length L with 1 <= L <= `MAX_SEG` yields one header with kind 2'b00 (single) and length L.
- R4: A PDU longer than `MAX_SEG` yields headers in the order: kind 2'b01 (start), then kind 2'b10 (continuation) zero or more times, then kind 2'b11 (end). The number of headers is ceil(L / `MAX_SEG`).
- R5: Every start and continuation header has length `MAX_SEG`. The end header has length L - (n-1)*`MAX_SEG`, a value between 1 and `MAX_SEG`.
- R6: Every header carries `hdr_ftype` = 4'd9 and `hdr_sid` equal to the `cmd_sid` that was accepted with the command.
- R7: While a header is pending (`hdr_valid` = 1), `in_ready` and `out_valid` are 0. A segment's payload flows only after its header is accepted.
- R8: `cmd_ready` is 0 from the cycle after a valid command's handshake until the final payload byte of the last segment transfers. It is 1 in the following cycle.
- R9: In the payload phase `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` equals `in_data`. A byte moves only when both sides handshake.
- R10: `out_last` is 1 exactly on the final byte of each segment.
- R11: A header not yet accepted stays valid with unchanged kind, length and stream identifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | PDU command valid |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_len | input | 17 | PDU length in bytes |
| cmd_sid | input | 16 | Stream identifier |
| cmd_err | output | 1 | One-cycle pulse: rejected length |
| hdr_valid | output | 1 | Segment header valid |
| hdr_ready | input | 1 | Header consumer ready |
| hdr_ftype | output | 4 | Format type, always 9 |
| hdr_kind | output | 2 | 00 single, 01 start, 10 continuation, 11 end |
| hdr_sid | output | 16 | Stream identifier of the PDU |
| hdr_len | output | 9 | Payload bytes in this segment |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Payload consumer ready |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final byte of the current segment |

## Verification
The hardest state to reach is the largest legal PDU. It runs the remaining-byte count from 65536 down through thousands of segment boundaries and ends on an exact multiple of the segment size. The bench gets there by building the segmenter with a 16-byte segment size. It then streams a full 65536-byte PDU at full rate and checks every header's kind and length along the way. The boundary just beyond that size (65537) and the zero length are sent as rejections. Header and payload stalls are mixed into a three-segment PDU, so that hold behaviour and pass-through back-pressure are exercised at segment edges.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'b00,
    KIND_START  = 2'b01,
    KIND_CONT   = 2'b10,
    KIND_END    = 2'b11
  } seg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } seg_state_e;

  localparam logic [3:0] FTYPE_STREAM = 4'd9;

endpackage

// File: rtl/dseg_plan.sv
module dseg_plan
  import dseg_pkg::*;
#(
  parameter int MAX_SEG = 256,
  parameter int LEN_W   = 17,
  parameter int SEG_W   = 9
) (
  input  logic [LEN_W-1:0] rem_bytes,
  input  logic             first_seg,
  output seg_kind_e        kind,
  output logic [SEG_W-1:0] seg_len
);

  logic fits;

  assign fits = (rem_bytes <= LEN_W'(MAX_SEG));

  always_comb begin
    if (fits) begin
      kind    = first_seg ? KIND_SINGLE : KIND_END;
      seg_len = SEG_W'(rem_bytes);
    end else begin
      kind    = first_seg ? KIND_START : KIND_CONT;
      seg_len = SEG_W'(MAX_SEG);
    end
  end

endmodule

// File: rtl/dseg_seg_cnt.sv
module dseg_seg_cnt #(
  parameter int SEG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEG_W-1:0] load_val,
  input  logic             beat,
  output logic             at_last
);

  logic [SEG_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (beat) begin
      left_q <= left_q - SEG_W'(1);
    end
  end

  assign at_last = (left_q == SEG_W'(1));

endmodule

// File: rtl/ds_segmenter.sv
module ds_segmenter
  import dseg_pkg::*;
#(
  parameter int MAX_SEG = 256,
  parameter int MAX_PDU = 65536,
  parameter int SID_W   = 16,
  parameter int DATA_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [$clog2(MAX_PDU+1)-1:0]  cmd_len,
  input  logic [SID_W-1:0]              cmd_sid,
  output logic                          cmd_err,
  output logic                          hdr_valid,
  input  logic                          hdr_ready,
  output logic [3:0]                    hdr_ftype,
  output logic [1:0]                    hdr_kind,
  output logic [SID_W-1:0]              hdr_sid,
  output logic [$clog2(MAX_SEG+1)-1:0]  hdr_len,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [DATA_W-1:0]             in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [DATA_W-1:0]             out_data,
  output logic                          out_last
);

  localparam int LEN_W = $clog2(MAX_PDU + 1);
  localparam int SEG_W = $clog2(MAX_SEG + 1);

  seg_state_e       state_q;
  logic [LEN_W-1:0] rem_q;
  logic             first_q;
  logic [SID_W-1:0] sid_q;
  logic             err_q;

  seg_kind_e        plan_kind;
  logic [SEG_W-1:0] plan_len;
  logic             seg_last;
  logic             len_bad;
  logic             hdr_fire;
  logic             pay_phase;
  logic             out_fire;

  dseg_plan #(
    .MAX_SEG (MAX_SEG),
    .LEN_W   (LEN_W),
    .SEG_W   (SEG_W)
  ) u_plan (
    .rem_bytes (rem_q),
    .first_seg (first_q),
    .kind      (plan_kind),
    .seg_len   (plan_len)
  );

  dseg_seg_cnt #(
    .SEG_W (SEG_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hdr_fire),
    .load_val (plan_len),
    .beat     (out_fire),
    .at_last  (seg_last)
  );

  assign len_bad   = (cmd_len == '0) || (cmd_len > LEN_W'(MAX_PDU));
  assign pay_phase = (state_q == ST_PAY);
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign out_fire  = out_valid && out_ready;

  assign cmd_ready = (state_q == ST_IDLE);
  assign cmd_err   = err_q;

  assign hdr_valid = (state_q == ST_HDR);
  assign hdr_ftype = FTYPE_STREAM;
  assign hdr_kind  = plan_kind;
  assign hdr_sid   = sid_q;
  assign hdr_len   = plan_len;

  assign out_valid = in_valid && pay_phase;
  assign in_ready  = out_ready && pay_phase;
  assign out_data  = in_data;
  assign out_last  = pay_phase && seg_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      first_q <= 1'b0;
      sid_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (len_bad) begin
              err_q <= 1'b1;
            end else begin
              rem_q   <= cmd_len;
              sid_q   <= cmd_sid;
              first_q <= 1'b1;
              state_q <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (hdr_ready) begin
            first_q <= 1'b0;
            state_q <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (out_fire) begin
            rem_q <= rem_q - LEN_W'(1);
            if (seg_last) begin
              state_q <= (rem_q == LEN_W'(1)) ? ST_IDLE : ST_HDR;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ds_segmenter_chk.sv
module ds_segmenter_chk #(
  parameter int MAX_SEG = 256,
  parameter int SID_W   = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_ready,
  input logic                         cmd_err,
  input logic                         hdr_valid,
  input logic                         hdr_ready,
  input logic [1:0]                   hdr_kind,
  input logic [SID_W-1:0]             hdr_sid,
  input logic [$clog2(MAX_SEG+1)-1:0] hdr_len,
  input logic                         in_ready,
  input logic                         out_valid
);

  // R11
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_kind) && $stable(hdr_len) && $stable(hdr_sid));

  // R7
  hdr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> !in_ready && !out_valid);

  // R2
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err);

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> cmd_ready && !hdr_valid);

  // R5
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (hdr_len != '0) && (int'(hdr_len) <= MAX_SEG));

  // R5
  full_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && (hdr_kind == 2'b01 || hdr_kind == 2'b10) |-> int'(hdr_len) == MAX_SEG);

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> !cmd_ready);

endmodule

bind ds_segmenter ds_segmenter_chk #(
  .MAX_SEG (MAX_SEG),
  .SID_W   (SID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .cmd_err   (cmd_err),
  .hdr_valid (hdr_valid),
  .hdr_ready (hdr_ready),
  .hdr_kind  (hdr_kind),
  .hdr_sid   (hdr_sid),
  .hdr_len   (hdr_len),
  .in_ready  (in_ready),
  .out_valid (out_valid)
);

// File: tb/test_ds_segmenter.sv
`timescale 1ns/1ps
module test_ds_segmenter;

  localparam int MSS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [16:0] cmd_len = '0;
  logic [15:0] cmd_sid = '0;
  logic        cmd_err;
  logic        hdr_valid;
  logic        hdr_ready = 1'b0;
  logic [3:0]  hdr_ftype;
  logic [1:0]  hdr_kind;
  logic [15:0] hdr_sid;
  logic [4:0]  hdr_len;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ds_segmenter #(.MAX_SEG(MSS)) i_ds_segmenter (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
    .cmd_sid(cmd_sid), .cmd_err(cmd_err),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_ftype(hdr_ftype),
    .hdr_kind(hdr_kind), .hdr_sid(hdr_sid), .hdr_len(hdr_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input int len, input int sid);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_len   = 17'(len);
    cmd_sid   = 16'(sid);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
    chk(hdr_valid == 1'b0, "R1 hdr_valid", int'(hdr_valid), 0);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
    chk(cmd_err == 1'b0, "R1 cmd_err", int'(cmd_err), 0);
  endtask

  // R2
  task automatic t_reject(input int len);
    do_cmd(len, 16'h5a5a);
    chk(cmd_err == 1'b1, "R2 err pulse", int'(cmd_err), 1);
    chk(hdr_valid == 1'b0, "R2 no header", int'(hdr_valid), 0);
    chk(cmd_ready == 1'b1, "R2 still ready", int'(cmd_ready), 1);
    @(negedge clk);
    chk(cmd_err == 1'b0, "R2 err one cycle", int'(cmd_err), 0);
    chk(hdr_valid == 1'b0, "R2 no header later", int'(hdr_valid), 0);
  endtask

  // R3 R4 R5 R6 R7 R8 R9 R10 R11
  task automatic t_pdu(input int len, input int sid, input int hstall, input bit stall);
    int n;
    int b;
    int c;
    n = (len + MSS - 1) / MSS;
    b = 0;
    c = 0;
    do_cmd(len, sid);
    chk(cmd_ready == 1'b0, "R8 busy after accept", int'(cmd_ready), 0);
    for (int i = 0; i < n; i++) begin
      int ek;
      int el;
      ek = (n == 1) ? 0 : (i == 0) ? 1 : (i == n - 1) ? 3 : 2;
      el = (i < n - 1) ? MSS : len - (n - 1) * MSS;
      in_valid  = 1'b1;
      out_ready = 1'b1;
      hdr_ready = 1'b0;
      for (int h = 0; h < hstall; h++) begin
        #1;
        chk(hdr_valid == 1'b1, "R11 header held", int'(hdr_valid), 1);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R7 no payload before header",
            int'({in_ready, out_valid}), 0);
        chk(cmd_ready == 1'b0, "R8 busy while header pending", int'(cmd_ready), 0);
        @(negedge clk);
      end
      in_valid = 1'b0;
      #1;
      chk(hdr_valid == 1'b1, "R3/R4 header present", int'(hdr_valid), 1);
      if (ek == 0) chk(hdr_kind == 2'(ek), "R3 single kind", int'(hdr_kind), ek);
      else         chk(hdr_kind == 2'(ek), "R4 kind order", int'(hdr_kind), ek);
      chk(int'(hdr_len) == el, "R5 segment length", int'(hdr_len), el);
      chk(hdr_ftype == 4'd9, "R6 ftype", int'(hdr_ftype), 9);
      chk(hdr_sid == 16'(sid), "R6 stream id", int'(hdr_sid), sid);
      hdr_ready = 1'b1;
      @(negedge clk);
      hdr_ready = 1'b0;
      for (int k = 0; k < el; k++) begin
        bit moved;
        moved = 1'b0;
        while (!moved) begin
          bit iv;
          bit orr;
          iv  = stall ? (c % 3 != 1) : 1'b1;
          orr = stall ? (c % 4 != 2) : 1'b1;
          c++;
          in_valid  = iv;
          out_ready = orr;
          in_data   = 8'(b + sid * 3);
          #1;
          chk(out_valid == iv, "R9 valid follows input", int'(out_valid), int'(iv));
          chk(in_ready == orr, "R9 ready follows output", int'(in_ready), int'(orr));
          if (iv && orr) begin
            chk(out_data == 8'(b + sid * 3), "R9 data", int'(out_data), int'(8'(b + sid * 3)));
            chk(out_last == (k == el - 1), "R10 last flag", int'(out_last), int'(k == el - 1));
            moved = 1'b1;
            b++;
          end
          @(negedge clk);
        end
      end
      in_valid  = 1'b0;
      out_ready = 1'b0;
      if (i < n - 1) chk(cmd_ready == 1'b0, "R8 busy between segments", int'(cmd_ready), 0);
    end
    #1;
    chk(cmd_ready == 1'b1, "R8 ready after last byte", int'(cmd_ready), 1);
    chk(hdr_valid == 1'b0, "R4 no extra header", int'(hdr_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pdu(1, 16'h0001, 0, 1'b0);        // R3 smallest
    t_pdu(MSS, 16'hbeef, 2, 1'b0);      // R3 exactly one segment
    t_pdu(MSS + 1, 16'h1234, 0, 1'b0);  // R4 start then end of one byte
    t_pdu(3 * MSS, 16'h00ff, 3, 1'b1);  // R4 start cont end, stalls
    t_pdu(2 * MSS + 5, 16'hffff, 1, 1'b1);
    t_reject(0);                        // R2 zero length
    t_reject(65537);                    // R2 over limit
    t_pdu(65536, 16'h7777, 0, 1'b0);    // R5 largest PDU
    t_reject(0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule